// File: doc/BRIEF.md
# Lane-Masked Variable-Length Vector ALU

This block is a SIMD integer execution unit whose active width is carried by each instruction. Along with the opcode and two source vectors, every request brings the current contents of the destination register and a lane count. Lanes below that count are computed and written. Every lane at or above it keeps its old destination element, raises no fault and asserts no write request. Because the count travels with the instruction, two consecutive requests may use different widths with no setup step and no idle cycle between them.

The vector is built from 32-bit elements. The lane count parameter is normally 4, 8 or 16, which gives 128, 256 or 512 bits. The active lanes always form a contiguous group that starts at lane 0. The count field is one bit wider than log2 of the lane count, so it can encode every value from an empty vector up to a full one. Results are registered once. Each request therefore returns its result vector, its per-lane write requests and its fault flag exactly one cycle later. A sticky fault output records every divide-by-zero seen since reset.

Top module: `vl_lane_alu`

## Requirements
- R1: A request accepted with `in_valid` high produces `out_valid` high, together with its result, write requests and fault flag, on the following clock edge and not earlier or later.
- R2: A count c enables lanes 0 to c-1, and `out_lane_wr` shows exactly that set. A count above the lane total enables all lanes.
- R3: Each enabled lane returns the opcode's result on its 32-bit elements. The opcodes are 0 add, 1 subtract (a minus b), 2 AND, 3 OR, 4 XOR, 5 signed multiply keeping the low 32 bits, and 6 signed divide (a over b, truncated toward zero).
- R4: Every lane that is not enabled returns its element of `in_dest_old` unchanged.
- R5: A count of 0 makes the request a no-op. The whole result equals `in_dest_old`, no lane write is requested and no fault is raised.
- R6: A divide lane whose divisor is zero returns all ones. It raises `out_div_zero` only when that lane is enabled. A zero divisor in a disabled lane, or in any lane under any other opcode, raises nothing.
- R7: `out_div_zero_sticky` is set by any raised `out_div_zero` in the same cycle and then stays high until reset.
- R8: Back-to-back requests with different counts and opcodes each produce their own correct result on consecutive cycles, with no bubble.
- R9: Opcode 7 is reserved. It behaves as a no-op whatever the count: result equals `in_dest_old`, no write is requested and no fault is raised.
- R10: During and right after reset, all outputs are zero.
- R11: A signed divide of the most negative value by -1 returns the most negative value. A multiply returns the low 32 bits of the full signed product.
- R12: A cycle without `in_valid` leaves `out_result` unchanged from the previous output and drives `out_valid`, `out_lane_wr` and `out_div_zero` low one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 3 | Opcode (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 mul, 6 div, 7 reserved) |
| in_count | input | $clog2(LANES)+1 | Number of active low-order lanes |
| in_src_a | input | LANES*EW | First source vector |
| in_src_b | input | LANES*EW | Second source vector |
| in_dest_old | input | LANES*EW | Current destination contents |
| out_valid | output | 1 | Result present |
| out_result | output | LANES*EW | Merged result vector |
| out_lane_wr | output | LANES | Per-lane write request |
| out_div_zero | output | 1 | Divide-by-zero in an enabled lane of this result |
| out_div_zero_sticky | output | 1 | Divide-by-zero seen since reset |

## Verification
The bench goes after the boundaries of the lane count. A count of zero must not write lane 0. A count of exactly the lane total must reach the top lane. A count above it must clamp rather than wrap, and a design that wraps would write too few lanes. Zero divisors are placed in lanes just past the active group; if faults were not masked by lane enable, the flag and the sticky bit would rise on a request that should be clean. Back-to-back requests with changing counts expose any design that holds the previous width for one cycle. The most negative value divided by -1, and products that overflow 32 bits, expose arithmetic that saturates or takes the wrong half of the product.

// File: rtl/vl_lane_alu.sv
module vl_lane_alu #(
  parameter int LANES = 8,
  parameter int EW    = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [2:0]                    in_op,
  input  logic [$clog2(LANES):0]        in_count,
  input  logic [LANES*EW-1:0]           in_src_a,
  input  logic [LANES*EW-1:0]           in_src_b,
  input  logic [LANES*EW-1:0]           in_dest_old,
  output logic                          out_valid,
  output logic [LANES*EW-1:0]           out_result,
  output logic [LANES-1:0]              out_lane_wr,
  output logic                          out_div_zero,
  output logic                          out_div_zero_sticky
);
  localparam int CW = $clog2(LANES) + 1;
  localparam int W  = LANES * EW;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_AND = 3'd2;
  localparam logic [2:0] OP_OR  = 3'd3;
  localparam logic [2:0] OP_XOR = 3'd4;
  localparam logic [2:0] OP_MUL = 3'd5;
  localparam logic [2:0] OP_DIV = 3'd6;
  localparam logic [2:0] OP_RSV = 3'd7;

  localparam logic [EW-1:0] MOST_NEG = {1'b1, {(EW-1){1'b0}}};

  logic [CW-1:0]    count_sat;
  logic             op_live;
  logic [LANES-1:0] lane_en;
  logic [LANES-1:0] lane_fault;
  logic [W-1:0]     merged;

  assign count_sat = (in_count > CW'(LANES)) ? CW'(LANES) : in_count;
  assign op_live   = (in_op != OP_RSV);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [EW-1:0] a, b, old, r, b_safe;
    logic          zero_div;

    assign a        = in_src_a[i*EW +: EW];
    assign b        = in_src_b[i*EW +: EW];
    assign old      = in_dest_old[i*EW +: EW];
    assign lane_en[i] = op_live && (count_sat > CW'(i));
    assign zero_div = (in_op == OP_DIV) && (b == '0);
    assign b_safe   = (b == '0) ? EW'(1) : b;

    always_comb begin
      case (in_op)
        OP_ADD:  r = a + b;
        OP_SUB:  r = a - b;
        OP_AND:  r = a & b;
        OP_OR:   r = a | b;
        OP_XOR:  r = a ^ b;
        OP_MUL:  r = a * b;
        OP_DIV: begin
          if (b == '0)                          r = '1;
          else if (a == MOST_NEG && b == '1)    r = MOST_NEG;
          else                                  r = $signed(a) / $signed(b_safe);
        end
        default: r = old;
      endcase
    end

    assign lane_fault[i]         = zero_div & lane_en[i];
    assign merged[i*EW +: EW]    = lane_en[i] ? r : old;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid           <= 1'b0;
      out_result          <= '0;
      out_lane_wr         <= '0;
      out_div_zero        <= 1'b0;
      out_div_zero_sticky <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result          <= merged;
        out_lane_wr         <= lane_en;
        out_div_zero        <= |lane_fault;
        out_div_zero_sticky <= out_div_zero_sticky | (|lane_fault);
      end else begin
        out_lane_wr  <= '0;
        out_div_zero <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vl_lane_alu_chk.sv
module vl_lane_alu_chk #(
  parameter int LANES = 8,
  parameter int EW    = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic [2:0]             in_op,
  input logic [$clog2(LANES):0] in_count,
  input logic [LANES*EW-1:0]    in_dest_old,
  input logic                   out_valid,
  input logic [LANES*EW-1:0]    out_result,
  input logic [LANES-1:0]       out_lane_wr,
  input logic                   out_div_zero,
  input logic                   out_div_zero_sticky
);
  localparam int CW = $clog2(LANES) + 1;

  function automatic int sat_cnt(logic [CW-1:0] c);
    return (int'(c) > LANES) ? LANES : int'(c);
  endfunction

  p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && out_lane_wr == '0 && !out_div_zero && $stable(out_result)));

  p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op != 3'd7) |=> ($countones(out_lane_wr) == sat_cnt($past(in_count))));

  p_contig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_lane_wr & (out_lane_wr + LANES'(1))) == '0));

  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd7) |=> (out_lane_wr == '0 && !out_div_zero && out_result == $past(in_dest_old)));

  p_fault_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op != 3'd6) |=> !out_div_zero);

  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_div_zero_sticky |=> out_div_zero_sticky);

  p_sticky_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_div_zero |-> out_div_zero_sticky);

  for (genvar i = 0; i < LANES; i++) begin : g_hold
    p_keep_old_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_count == '0) |=> (out_result[i*EW +: EW] == $past(in_dest_old[i*EW +: EW])));
  end
endmodule

bind vl_lane_alu vl_lane_alu_chk #(.LANES(LANES), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
  .in_count(in_count), .in_dest_old(in_dest_old), .out_valid(out_valid),
  .out_result(out_result), .out_lane_wr(out_lane_wr),
  .out_div_zero(out_div_zero), .out_div_zero_sticky(out_div_zero_sticky));

// File: tb/test_vl_lane_alu.sv
`timescale 1ns/1ps
module test_vl_lane_alu;
  localparam int LANES = 8;
  localparam int EW    = 32;
  localparam int CW    = $clog2(LANES) + 1;
  localparam int W     = LANES * EW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n;
  logic             in_valid;
  logic [2:0]       in_op;
  logic [CW-1:0]    in_count;
  logic [W-1:0]     in_src_a, in_src_b, in_dest_old;
  logic             out_valid;
  logic [W-1:0]     out_result;
  logic [LANES-1:0] out_lane_wr;
  logic             out_div_zero, out_div_zero_sticky;

  vl_lane_alu #(.LANES(LANES), .EW(EW)) i_vl_lane_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_count(in_count), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_dest_old(in_dest_old), .out_valid(out_valid), .out_result(out_result),
    .out_lane_wr(out_lane_wr), .out_div_zero(out_div_zero),
    .out_div_zero_sticky(out_div_zero_sticky));

  int checks = 0;
  int fails  = 0;

  logic             e_valid;
  logic [W-1:0]     e_res;
  logic [LANES-1:0] e_wr;
  logic             e_dz, e_sticky;
  string            e_tag;

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("R1", "out_valid", W'(out_valid), W'(e_valid));
    chk("R2", "out_lane_wr", W'(out_lane_wr), W'(e_wr));
    for (int i = 0; i < LANES; i++) begin
      string t;
      t = (e_tag != "") ? e_tag : (e_wr[i] ? "R3" : "R4");
      chk(t, $sformatf("lane %0d", i), W'(out_result[i*EW +: EW]), W'(e_res[i*EW +: EW]));
    end
    chk("R6", "out_div_zero", W'(out_div_zero), W'(e_dz));
    chk("R7", "out_div_zero_sticky", W'(out_div_zero_sticky), W'(e_sticky));
  endtask

  function automatic logic [EW-1:0] lane_ref(logic [2:0] op, logic [EW-1:0] x, logic [EW-1:0] y);
    longint p;
    case (op)
      3'd0: return x + y;
      3'd1: return x - y;
      3'd2: return x & y;
      3'd3: return x | y;
      3'd4: return x ^ y;
      3'd5: begin
        p = longint'($signed(x)) * longint'($signed(y));
        return p[EW-1:0];
      end
      default: begin
        if (y == 0) return '1;
        if (x == 32'h8000_0000 && y == 32'hFFFF_FFFF) return x;
        p = longint'($signed(x)) / longint'($signed(y));
        return p[EW-1:0];
      end
    endcase
  endfunction

  task automatic issue(logic [2:0] op, int cnt, logic [W-1:0] a, logic [W-1:0] b,
                       logic [W-1:0] old, string tag);
    int sat;
    @(negedge clk);
    compare();
    in_valid = 1'b1; in_op = op; in_count = CW'(cnt);
    in_src_a = a; in_src_b = b; in_dest_old = old;
    sat = (cnt > LANES) ? LANES : cnt;
    e_valid = 1'b1; e_dz = 1'b0; e_tag = tag;
    for (int i = 0; i < LANES; i++) begin
      logic en;
      en = (op != 3'd7) && (i < sat);
      e_wr[i] = en;
      if (en) begin
        e_res[i*EW +: EW] = lane_ref(op, a[i*EW +: EW], b[i*EW +: EW]);
        if (op == 3'd6 && b[i*EW +: EW] == 0) e_dz = 1'b1;
      end else begin
        e_res[i*EW +: EW] = old[i*EW +: EW];
      end
    end
    e_sticky = e_sticky | e_dz;
  endtask

  task automatic idle();
    @(negedge clk);
    compare();
    in_valid = 1'b0;
    in_src_a = {LANES{32'hDEAD_0001}};
    in_dest_old = {LANES{32'h0BAD_0BAD}};
    e_valid = 1'b0; e_wr = '0; e_dz = 1'b0; e_tag = "R12";
  endtask

  function automatic logic [W-1:0] rvec(bit zeros);
    logic [W-1:0] v;
    for (int i = 0; i < LANES; i++) begin
      v[i*EW +: EW] = $urandom;
      if (zeros && ($urandom % 4 == 0)) v[i*EW +: EW] = '0;
    end
    return v;
  endfunction

  function automatic logic [W-1:0] ramp(logic [EW-1:0] base);
    logic [W-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*EW +: EW] = base + EW'(i);
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] b;
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_count = '0;
    in_src_a = '0; in_src_b = '0; in_dest_old = '0;
    e_valid = 0; e_res = '0; e_wr = '0; e_dz = 0; e_sticky = 0; e_tag = "R10";
    repeat (3) @(negedge clk);
    chk("R10", "reset out_valid", W'(out_valid), '0);
    chk("R10", "reset out_result", out_result, '0);
    chk("R10", "reset out_lane_wr", W'(out_lane_wr), '0);
    chk("R10", "reset flags", W'({out_div_zero, out_div_zero_sticky}), '0);
    rst_n = 1'b1;

    issue(3'd0, LANES, ramp(32'h100), ramp(32'h1000), ramp(32'h7777), "");
    // R8: counts change on every cycle, no gap
    issue(3'd1, 3, ramp(32'h50), ramp(32'h10), ramp(32'hA000), "R8");
    issue(3'd2, 1, rvec(0), rvec(0), rvec(0), "R8");
    issue(3'd3, 5, rvec(0), rvec(0), rvec(0), "R8");
    issue(3'd4, LANES, rvec(0), rvec(0), rvec(0), "R8");
    // R5: count zero is a no-op
    issue(3'd0, 0, rvec(0), rvec(0), ramp(32'h5555), "R5");
    // R2: count above the lane total clamps
    issue(3'd4, 15, rvec(0), rvec(0), rvec(0), "R2");
    issue(3'd4, LANES + 1, rvec(0), rvec(0), rvec(0), "R2");
    // R9: reserved opcode
    issue(3'd7, LANES, rvec(0), rvec(0), ramp(32'h9900), "R9");
    // R6: zero divisors only in disabled lanes, then one enabled
    b = '0;
    b[0 +: EW] = 32'd3; b[EW +: EW] = 32'hFFFF_FFFD;
    issue(3'd6, 2, ramp(32'd100), b, rvec(0), "R6");
    issue(3'd0, LANES, rvec(0), '0, rvec(0), "R6");
    issue(3'd6, 3, ramp(32'd100), b, rvec(0), "R6");
    // R11: overflow corners
    b = {LANES{32'hFFFF_FFFF}};
    issue(3'd6, LANES, {LANES{32'h8000_0000}}, b, rvec(0), "R11");
    issue(3'd5, LANES, {LANES{32'h7FFF_FFFF}}, {LANES{32'h7FFF_FFFF}}, rvec(0), "R11");
    issue(3'd5, LANES, {LANES{32'h8000_0000}}, {LANES{32'hFFFF_FFFF}}, rvec(0), "R11");
    // R12 and R7: idle holds result, sticky remains
    idle(); idle(); idle();

    for (int n = 0; n < 400; n++) begin
      if ($urandom % 5 == 0) idle();
      else issue(3'($urandom % 8), int'($urandom % (2*LANES)), rvec(0), rvec(1), rvec(0), "");
    end
    idle();
    @(negedge clk);
    compare();

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule